// File: doc/BRIEF.md
# Write Enable and Status Protection Unit

This block guards writes in a serial nonvolatile memory. The serial controller decodes each frame and sends it single-cycle command pulses: arm, disarm, status write (with its data byte) and memory-write-finished. The block holds an arm latch and three user status bits. It gives back the status byte for read frames and two permit flags. The controller checks one flag before committing a memory write and the other before committing a status write.

The arm latch is set only by an explicit arm command. It can never be loaded through the status byte. Any completed write drops it, so every write needs a fresh arm. An active-low protect pin, brought into the clock domain through a short synchronizer, blocks status writes. It has no effect on memory writes. Power-on reset is modelled as a synchronous active-high reset.

Top module: `wen_guard`

## Requirements
- R1: While `rst` is high at a clock edge, the arm latch clears, the user status bits load `NV_INIT` (default 0), and the protect synchronizer loads 0 (protected). After reset, `stat_byte` is 8'h00 and both permit flags are 0.
- R2: An `arm` pulse sets the latch at that edge, when no clearing pulse arrives in the same cycle. The latch is visible as bit 1 of `stat_byte`.
- R3: A `disarm` pulse clears the latch at that edge.
- R4: A `mem_wr_done` pulse clears the latch at that edge.
- R5: A `stat_wr` pulse clears the latch at that edge, whether or not the status update was allowed.
- R6: Bit 1 of `stat_wdata` never sets the latch. Bits 0, 4, 5 and 6 of `stat_byte` always read 0.
- R7: A `stat_wr` pulse updates bits 2, 3 and 7 of `stat_byte` from the same bits of `stat_wdata` at that edge. This happens only when the latch is 1 and the synchronized protect level is 1.
- R8: A `stat_wr` pulse while the latch is 0 leaves bits 2, 3 and 7 unchanged.
- R9: A `stat_wr` pulse while the synchronized protect level is 0 leaves bits 2, 3 and 7 unchanged.
- R10: `mem_wr_ok` equals the latch. `stat_wr_ok` equals the latch ANDed with `wp_n` delayed by `SYNC_STAGES` clock edges (default 2).
- R11: A clearing pulse (`disarm`, `mem_wr_done` or `stat_wr`) wins over `arm` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| arm | input | 1 | Arm command pulse |
| disarm | input | 1 | Disarm command pulse |
| stat_wr | input | 1 | Status write command pulse |
| stat_wdata | input | 8 | Data byte for the status write |
| mem_wr_done | input | 1 | Memory write completed pulse |
| wp_n | input | 1 | Active-low protect pin, asynchronous |
| stat_byte | output | 8 | Status byte for reads |
| mem_wr_ok | output | 1 | Memory writes permitted |
| stat_wr_ok | output | 1 | Status writes permitted |

## Verification
The assertions assume every command input is a single-cycle pulse that is sampled cleanly on the clock. They also assume `wp_n` reaches the synchronizer without glitches between edges. The bench drives all inputs on the falling edge, so each pulse lasts exactly one rising edge. The protect pin likewise changes only on the falling edge. Directed phases hit each clearing source, the same-cycle conflicts and the protect latency. A random phase then mixes pulses, including several asserted together.

// File: rtl/wen_guard_pkg.sv
package wen_guard_pkg;
  localparam int STAT_W   = 8;
  localparam int WEL_POS  = 1;
  localparam logic [STAT_W-1:0] USER_MASK = 8'h8C;
endpackage

// File: rtl/wen_pin_sync.sv
module wen_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic pin_q
);
  localparam int LAST = STAGES - 1;
  logic [STAGES-1:0] stg;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= 1'b0;
          else     stg[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= 1'b0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign pin_q = stg[LAST];
endmodule

// File: rtl/wen_latch.sv
module wen_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  output logic wel
);
  always_ff @(posedge clk) begin
    if (rst)          wel <= 1'b0;
    else if (clr_req) wel <= 1'b0;
    else if (set_req) wel <= 1'b1;
  end

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    (set_req && !clr_req) |=> wel);
  p_clear_r11: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> !wel);
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!set_req && !clr_req) |=> $stable(wel));
endmodule

// File: rtl/wen_status_bits.sv
module wen_status_bits #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '0,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_go,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] bits
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      if (MASK[i]) begin : g_keep
        always_ff @(posedge clk) begin
          if (rst)        bits[i] <= INIT[i];
          else if (wr_go) bits[i] <= wdata[i];
        end
      end else begin : g_zero
        assign bits[i] = 1'b0;
      end
    end
  endgenerate

  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> (bits == ($past(wdata) & MASK)));
  p_keep_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_go |=> $stable(bits));
endmodule

// File: rtl/wen_guard.sv
module wen_guard
  import wen_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [STAT_W-1:0] NV_INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              disarm,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  input  logic              mem_wr_done,
  input  logic              wp_n,
  output logic [STAT_W-1:0] stat_byte,
  output logic              mem_wr_ok,
  output logic              stat_wr_ok
);
  localparam logic [STAT_W-1:0] INIT_M = NV_INIT & USER_MASK;

  logic wp_q;
  logic wel;
  logic clr_any;
  logic upd;
  logic [STAT_W-1:0] user_bits;

  wen_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(wp_n), .pin_q(wp_q)
  );

  assign clr_any = disarm | mem_wr_done | stat_wr;

  wen_latch u_latch (
    .clk(clk), .rst(rst), .set_req(arm), .clr_req(clr_any), .wel(wel)
  );

  assign upd = stat_wr & wel & wp_q;

  wen_status_bits #(.W(STAT_W), .MASK(USER_MASK), .INIT(INIT_M)) u_bits (
    .clk(clk), .rst(rst), .wr_go(upd), .wdata(stat_wdata), .bits(user_bits)
  );

  always_comb begin
    stat_byte = user_bits;
    stat_byte[WEL_POS] = wel;
  end

  assign mem_wr_ok  = wel;
  assign stat_wr_ok = wel & wp_q;

  p_protect_r9: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !wp_q) |=> ((stat_byte & USER_MASK) == $past(stat_byte & USER_MASK)));
  p_swdrop_r5: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> !mem_wr_ok);
  p_nosetbit_r6: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && !arm) |=> !stat_byte[WEL_POS]);
endmodule

// File: tb/wen_guard_tb.sv
module wen_guard_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 0, disarm = 0, stat_wr = 0, mem_wr_done = 0, wp_n = 0;
  logic [7:0] stat_wdata = 8'h00;
  logic [7:0] stat_byte;
  logic mem_wr_ok, stat_wr_ok;

  localparam int NS = 2;

  always #4 clk = ~clk;

  wen_guard #(.SYNC_STAGES(NS)) u_dut (
    .clk(clk), .rst(rst), .arm(arm), .disarm(disarm), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .mem_wr_done(mem_wr_done), .wp_n(wp_n),
    .stat_byte(stat_byte), .mem_wr_ok(mem_wr_ok), .stat_wr_ok(stat_wr_ok)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit cmp_on = 0;

  // behavioural reference model
  bit m_wel;
  logic [7:0] m_nv;
  bit wq[$];

  always @(posedge clk) begin
    if (rst) begin
      m_wel = 0;
      m_nv = 8'h00;
      wq = {};
      for (int i = 0; i < NS; i++) wq.push_front(1'b0);
    end else begin
      bit eff;
      eff = wq[$];
      if (stat_wr && m_wel && eff) m_nv = stat_wdata & 8'h8C;
      if (disarm || mem_wr_done || stat_wr) m_wel = 0;
      else if (arm) m_wel = 1;
      wq.push_front(wp_n);
      void'(wq.pop_back());
    end
  end

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk8({cur_req, " stat_byte"}, stat_byte, m_nv | {6'b0, m_wel, 1'b0});
      chk8("R10 mem_wr_ok", {7'b0, mem_wr_ok}, {7'b0, m_wel});
      chk8("R10 stat_wr_ok", {7'b0, stat_wr_ok}, {7'b0, m_wel & wq[$]});
    end
  end

  task automatic step(input logic s, input logic c, input logic w,
                      input logic d, input logic [7:0] dat);
    @(negedge clk);
    arm = s; disarm = c; stat_wr = w; mem_wr_done = d; stat_wdata = dat;
    @(negedge clk);
    arm = 0; disarm = 0; stat_wr = 0; mem_wr_done = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  bit done = 0;
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    cur_req = "R1";
    chk8("R1 reset stat_byte", stat_byte, 8'h00);
    chk8("R1 reset permits", {6'b0, mem_wr_ok, stat_wr_ok}, 8'h00);
    @(negedge clk); rst = 0; cmp_on = 1;
    wp_n = 1; idle(3);

    cur_req = "R2"; step(1, 0, 0, 0, 8'h00);
    chk8("R2 latch set", stat_byte, 8'h02);
    chk8("R10 both permits", {6'b0, mem_wr_ok, stat_wr_ok}, 8'h03);
    cur_req = "R3"; step(0, 1, 0, 0, 8'h00);
    chk8("R3 disarm", stat_byte, 8'h00);

    cur_req = "R7"; step(1, 0, 0, 0, 8'h00); step(0, 0, 1, 0, 8'hFF);
    chk8("R6 R7 write FF", stat_byte, 8'h8C);
    cur_req = "R6"; step(1, 0, 0, 0, 8'h00); step(0, 0, 1, 0, 8'h76);
    chk8("R6 R7 write 76", stat_byte, 8'h04);
    cur_req = "R8"; step(0, 0, 1, 0, 8'h88);
    chk8("R8 unarmed write", stat_byte, 8'h04);
    cur_req = "R4"; step(1, 0, 0, 0, 8'h00); step(0, 0, 0, 1, 8'h00);
    chk8("R4 mem done clears", stat_byte, 8'h04);

    cur_req = "R9"; step(1, 0, 0, 0, 8'h00);
    @(negedge clk); wp_n = 0;
    @(negedge clk);
    chk8("R10 sync delay 1", {7'b0, stat_wr_ok}, 8'h01);
    @(negedge clk);
    chk8("R10 sync delay 2", {7'b0, stat_wr_ok}, 8'h00);
    chk8("R10 mem ok kept", {7'b0, mem_wr_ok}, 8'h01);
    step(0, 0, 1, 0, 8'h88);
    chk8("R9 R5 protected write", stat_byte, 8'h04);
    @(negedge clk); wp_n = 1; idle(3);

    cur_req = "R11"; step(1, 1, 0, 0, 8'h00);
    chk8("R11 arm+disarm", stat_byte, 8'h04);
    step(1, 0, 0, 1, 8'h00);
    chk8("R11 arm+done", stat_byte, 8'h04);
    step(1, 0, 0, 0, 8'h00); step(1, 0, 1, 0, 8'h0A);
    chk8("R11 arm+stat_wr", stat_byte, 8'h08);

    cur_req = "R5";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      arm = ($urandom_range(0, 2) == 0);
      disarm = ($urandom_range(0, 7) == 0);
      stat_wr = ($urandom_range(0, 4) == 0);
      mem_wr_done = ($urandom_range(0, 7) == 0);
      stat_wdata = 8'($urandom);
      if ($urandom_range(0, 9) == 0) wp_n = ~wp_n;
    end
    @(negedge clk);
    arm = 0; disarm = 0; stat_wr = 0; mem_wr_done = 0;
    idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule